// File: doc/BRIEF.md
# Low-Power SDRAM Power-Up Sequencer

This block brings a low-power DDR SDRAM from power-up to an operational state when user logic asks for it. A level-sensitive start request launches a fixed sequence. The block holds clock enable low through a long power-up wait. It then raises clock enable and issues, in order, a precharge of all banks, two auto-refresh commands, a mode-register load and an extended-mode-register load. It keeps the programmed wait after each command. Between the named commands the command bus carries NOP. Every wait is produced by one shared down-counter, which is reloaded whenever the state machine changes state.

On completion the block gives a single-cycle done pulse. From the next cycle it holds a ready flag, which tells a downstream scheduler that accesses may begin. A start request that is still high at the clock edge after the done pulse counts as a new request. So does any later start request while ready is high. Either one clears ready and runs the whole sequence again from the power-up wait.

The states are IDLE, PWRUP, CKE_NOP, PREA, WAIT_RP, AREF1, WAIT_RFC1, AREF2, WAIT_RFC2, LMR, WAIT_MRD1, LEMR, WAIT_MRD2, DONE and READY. The transitions are as follows:
- IDLE goes to PWRUP on start.
- PWRUP goes to CKE_NOP when its counter expires.
- CKE_NOP goes to PREA, and PREA goes to WAIT_RP; each of these takes one cycle.
- WAIT_RP goes to AREF1 on expiry.
- AREF1 goes to WAIT_RFC1, which goes to AREF2 on expiry.
- AREF2 goes to WAIT_RFC2, which goes to LMR on expiry.
- LMR goes to WAIT_MRD1, which goes to LEMR on expiry.
- LEMR goes to WAIT_MRD2, which goes to DONE on expiry.
- DONE goes to READY unconditionally.
- READY goes to PWRUP on start.
- A synchronous reset returns any state to IDLE.

Top module: `lpsdram_init_seq`

## Requirements
- R1: While reset is applied, and afterwards while start stays low, clock enable is 0, the command code is NOP (0), bank and address are 0, and both done and ready are 0.
- R2: Start is sampled high in IDLE at edge 1. Clock enable stays 0 with NOP for the T_PWRUP cycles observed after edges 1..T_PWRUP. It is 1 from edge T_PWRUP+1 onward. Clock enable low always implies NOP.
- R3: Let TP be T_PWRUP, with start sampled at edge 1. The commands follow edges at fixed offsets:
  - PRECHARGE ALL (code 1) follows edge TP+2.
  - AUTO REFRESH (code 2) follows edges TP+3+T_RP and TP+4+T_RP+T_RFC.
  - LOAD MODE (code 3) follows edge TP+5+T_RP+2·T_RFC.
  - LOAD EXTENDED MODE (code 4) follows edge TP+6+T_RP+2·T_RFC+T_MRD.
  - Every other cycle carries NOP.
- R4: PRECHARGE ALL drives address bit 10 high with all other address bits and the bank 0. LOAD MODE drives bank 0 and address MR_VALUE. LOAD EXTENDED MODE drives bank 2 and address EMR_VALUE. NOP and AUTO REFRESH drive bank 0 and address 0.
- R5: Done is 1 for exactly the one cycle after edge D = TP+7+T_RP+2·T_RFC+2·T_MRD. Ready is 0 until then, rises in the cycle after the pulse, and stays 1 while start is low.
- R6: Dropping start part-way through the sequence has no effect: the commands, done and ready follow the same cycle timing.
- R7: If start is still high at the edge after the done cycle, ready is 1 for one cycle and then clears. Clock enable returns to 0 and the full sequence repeats, with a second done pulse D cycles later.
- R8: A start request while ready is high clears ready at the next edge and reruns the full sequence with R3 timing.
- R9: A synchronous reset asserted mid-sequence returns the block to IDLE at the next edge, with R1 outputs, and no command follows while start stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_start | input | 1 | Level-sensitive initialization request |
| seq_done | output | 1 | One-cycle completion pulse |
| mem_ready | output | 1 | Memory usable by the command scheduler |
| mem_cke | output | 1 | SDRAM clock enable |
| mem_cmd | output | 3 | Command code: 0 NOP, 1 precharge all, 2 auto refresh, 3 load mode, 4 load extended mode |
| mem_bank | output | BA_W | Bank address; selects mode (0) or extended mode (2) register |
| mem_addr | output | ADDR_W | Address bus; carries the register value or the all-bank flag |

## Verification
The assertions assume that the delay parameters are all at least 1, and that start is a clean synchronous level. They also assume that reset is the only other input that can interrupt a run. The bench drives start and reset only on falling clock edges. It keeps every delay parameter small but non-zero, and it samples each output at the falling edge after the edge that changes it. The bench computes the expected command, bank, address, clock enable, done and ready for each cycle from the offsets in R3 and R5, and it uses no DUT internals.

// File: rtl/lpinit_pkg.sv
package lpinit_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PREA = 3'd1,
        CMD_AREF = 3'd2,
        CMD_LMR  = 3'd3,
        CMD_LEMR = 3'd4
    } mem_cmd_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PWRUP,
        S_CKE_NOP,
        S_PREA,
        S_WAIT_RP,
        S_AREF1,
        S_WAIT_RFC1,
        S_AREF2,
        S_WAIT_RFC2,
        S_LMR,
        S_WAIT_MRD1,
        S_LEMR,
        S_WAIT_MRD2,
        S_DONE,
        S_READY
    } seq_state_e;

endpackage

// File: rtl/lpinit_delay_ctr.sv
module lpinit_delay_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R3: a running wait shrinks by one per cycle unless reloaded
    a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R3: an expired counter holds at zero until reloaded
    a_r3_hold_zero: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/lpinit_cmd_drive.sv
module lpinit_cmd_drive
    import lpinit_pkg::*;
#(
    parameter int                ADDR_W    = 13,
    parameter int                BA_W      = 2,
    parameter int                AP_BIT    = 10,
    parameter logic [ADDR_W-1:0] MR_VALUE  = '0,
    parameter logic [ADDR_W-1:0] EMR_VALUE = '0
) (
    input  mem_cmd_e          cmd_sel,
    output logic [2:0]        cmd_code,
    output logic [BA_W-1:0]   bank,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [BA_W-1:0]   BANK_MR  = BA_W'(0);
    localparam logic [BA_W-1:0]   BANK_EMR = BA_W'(2);
    localparam logic [ADDR_W-1:0] ALL_BANK = ADDR_W'(1) << AP_BIT;

    always_comb begin
        cmd_code = cmd_sel;
        bank     = '0;
        addr     = '0;
        unique case (cmd_sel)
            CMD_PREA: addr = ALL_BANK;
            CMD_LMR: begin
                bank = BANK_MR;
                addr = MR_VALUE;
            end
            CMD_LEMR: begin
                bank = BANK_EMR;
                addr = EMR_VALUE;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lpsdram_init_seq.sv
module lpsdram_init_seq
    import lpinit_pkg::*;
#(
    parameter int                ADDR_W    = 13,
    parameter int                BA_W      = 2,
    parameter int                AP_BIT    = 10,
    parameter int                T_PWRUP   = 20000,
    parameter int                T_RP      = 3,
    parameter int                T_RFC     = 8,
    parameter int                T_MRD     = 2,
    parameter logic [ADDR_W-1:0] MR_VALUE  = 13'h0032,
    parameter logic [ADDR_W-1:0] EMR_VALUE = 13'h0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seq_start,
    output logic              seq_done,
    output logic              mem_ready,
    output logic              mem_cke,
    output logic [2:0]        mem_cmd,
    output logic [BA_W-1:0]   mem_bank,
    output logic [ADDR_W-1:0] mem_addr
);

    localparam int MAX_A = (T_PWRUP > T_RFC) ? T_PWRUP : T_RFC;
    localparam int MAX_B = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_D + 1);

    seq_state_e       state_q, state_d;
    mem_cmd_e         cmd_sel;
    logic             ctr_load;
    logic             ctr_expired;
    logic [CNT_W-1:0] ctr_val;

    // Cycles spent in a state, minus one; single-cycle states load zero
    function automatic logic [CNT_W-1:0] stay_len(seq_state_e s);
        unique case (s)
            S_PWRUP:                  return CNT_W'(T_PWRUP - 1);
            S_WAIT_RP:                return CNT_W'(T_RP - 1);
            S_WAIT_RFC1, S_WAIT_RFC2: return CNT_W'(T_RFC - 1);
            S_WAIT_MRD1, S_WAIT_MRD2: return CNT_W'(T_MRD - 1);
            default:                  return '0;
        endcase
    endfunction

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (seq_start)   state_d = S_PWRUP;
            S_PWRUP:     if (ctr_expired) state_d = S_CKE_NOP;
            S_CKE_NOP:                    state_d = S_PREA;
            S_PREA:                       state_d = S_WAIT_RP;
            S_WAIT_RP:   if (ctr_expired) state_d = S_AREF1;
            S_AREF1:                      state_d = S_WAIT_RFC1;
            S_WAIT_RFC1: if (ctr_expired) state_d = S_AREF2;
            S_AREF2:                      state_d = S_WAIT_RFC2;
            S_WAIT_RFC2: if (ctr_expired) state_d = S_LMR;
            S_LMR:                        state_d = S_WAIT_MRD1;
            S_WAIT_MRD1: if (ctr_expired) state_d = S_LEMR;
            S_LEMR:                       state_d = S_WAIT_MRD2;
            S_WAIT_MRD2: if (ctr_expired) state_d = S_DONE;
            S_DONE:                       state_d = S_READY;
            S_READY:     if (seq_start)   state_d = S_PWRUP;
            default:                      state_d = S_IDLE;
        endcase
    end

    assign ctr_load = (state_d != state_q);
    assign ctr_val  = stay_len(state_d);

    // Output logic
    always_comb begin
        cmd_sel   = CMD_NOP;
        mem_cke   = 1'b1;
        seq_done  = 1'b0;
        mem_ready = 1'b0;
        unique case (state_q)
            S_IDLE, S_PWRUP: mem_cke   = 1'b0;
            S_PREA:          cmd_sel   = CMD_PREA;
            S_AREF1,
            S_AREF2:         cmd_sel   = CMD_AREF;
            S_LMR:           cmd_sel   = CMD_LMR;
            S_LEMR:          cmd_sel   = CMD_LEMR;
            S_DONE:          seq_done  = 1'b1;
            S_READY:         mem_ready = 1'b1;
            default: ;
        endcase
    end

    lpinit_delay_ctr #(
        .CNT_W (CNT_W)
    ) u_delay (
        .clk      (clk),
        .rst      (rst),
        .load     (ctr_load),
        .load_val (ctr_val),
        .expired  (ctr_expired)
    );

    lpinit_cmd_drive #(
        .ADDR_W    (ADDR_W),
        .BA_W      (BA_W),
        .AP_BIT    (AP_BIT),
        .MR_VALUE  (MR_VALUE),
        .EMR_VALUE (EMR_VALUE)
    ) u_drive (
        .cmd_sel  (cmd_sel),
        .cmd_code (mem_cmd),
        .bank     (mem_bank),
        .addr     (mem_addr)
    );

    // R5: completion pulse lasts a single cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !seq_done);

    // R5: ready follows the completion pulse
    a_r5_ready_after_done: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> mem_ready);

    // R2: command bus is idle while clock enable is low
    a_r2_cke_low_nop: assert property (@(posedge clk) disable iff (rst)
        !mem_cke |-> (mem_cmd == 3'd0));

    // R3: completion only after the final mode-register wait
    a_r3_done_after_lemr: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> ($past(state_q) == S_WAIT_MRD2));

    // R4: only defined command codes appear
    a_r4_legal_code: assert property (@(posedge clk) disable iff (rst)
        mem_cmd <= 3'd4);

    // R8: ready drops only because of a new request or reset
    a_r8_ready_drop_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ready) |-> ($past(seq_start) || $past(rst)));

endmodule

// File: tb/lpsdram_init_seq_tb.sv
module lpsdram_init_seq_tb;

    localparam int          ADDR_W = 13;
    localparam int          BA_W   = 2;
    localparam int          TP     = 20;
    localparam int          TRP    = 3;
    localparam int          TRFC   = 5;
    localparam int          TMRD   = 2;
    localparam logic [12:0] MRV    = 13'h0032;
    localparam logic [12:0] EMRV   = 13'h0020;
    localparam int          DK     = TP + 7 + TRP + 2*TRFC + 2*TMRD;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              seq_start = 1'b0;
    logic              seq_done, mem_ready, mem_cke;
    logic [2:0]        mem_cmd;
    logic [BA_W-1:0]   mem_bank;
    logic [ADDR_W-1:0] mem_addr;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    lpsdram_init_seq #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(10),
        .T_PWRUP(TP), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD),
        .MR_VALUE(MRV), .EMR_VALUE(EMRV)
    ) u_dut (
        .clk(clk), .rst(rst), .seq_start(seq_start),
        .seq_done(seq_done), .mem_ready(mem_ready), .mem_cke(mem_cke),
        .mem_cmd(mem_cmd), .mem_bank(mem_bank), .mem_addr(mem_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_cmd(input int k);
        if (k == TP + 2)                          return 3'd1;
        if (k == TP + 3 + TRP)                    return 3'd2;
        if (k == TP + 4 + TRP + TRFC)             return 3'd2;
        if (k == TP + 5 + TRP + 2*TRFC)           return 3'd3;
        if (k == TP + 6 + TRP + 2*TRFC + TMRD)    return 3'd4;
        return 3'd0;
    endfunction

    function automatic logic [12:0] exp_addr(input logic [2:0] c);
        case (c)
            3'd1:    return 13'h0400;
            3'd3:    return MRV;
            3'd4:    return EMRV;
            default: return 13'h0000;
        endcase
    endfunction

    task automatic chk_idle(input string tag);
        chk(tag, {31'd0, mem_cke}, 32'd0);
        chk(tag, {29'd0, mem_cmd}, 32'd0);
        chk(tag, {30'd0, mem_bank}, 32'd0);
        chk(tag, {19'd0, mem_addr}, 32'd0);
        chk(tag, {31'd0, seq_done}, 32'd0);
        chk(tag, {31'd0, mem_ready}, 32'd0);
    endtask

    // Check cycle k of a run, k = edges since start was first sampled
    task automatic chk_cycle(input int k, input string dtag);
        logic [2:0] c;
        c = exp_cmd(k);
        chk("R2 cke", {31'd0, mem_cke}, (k > TP) ? 32'd1 : 32'd0);
        chk("R3 cmd", {29'd0, mem_cmd}, {29'd0, c});
        chk("R4 addr", {19'd0, mem_addr}, {19'd0, exp_addr(c)});
        chk("R4 bank", {30'd0, mem_bank}, (c == 3'd4) ? 32'd2 : 32'd0);
        chk(dtag, {31'd0, seq_done}, (k == DK) ? 32'd1 : 32'd0);
        chk(dtag, {31'd0, mem_ready}, (k > DK) ? 32'd1 : 32'd0);
    endtask

    // One full run; start dropped after cycle drop_k (0: at the done cycle)
    task automatic run_seq(input int drop_k, input string dtag);
        @(negedge clk);
        seq_start = 1'b1;
        for (int k = 1; k <= DK + 1; k++) begin
            @(negedge clk);
            chk_cycle(k, dtag);
            if (k == drop_k || k == DK) seq_start = 1'b0;
        end
    endtask

    task automatic t_reset_state;
        repeat (2) @(negedge clk);
        chk_idle("R1 in reset");
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk_idle("R1 idle after reset");
    endtask

    task automatic t_basic;
        run_seq(0, "R5 done/ready");
        repeat (6) @(negedge clk);
        chk("R5 ready held", {31'd0, mem_ready}, 32'd1);
        chk("R5 no extra done", {31'd0, seq_done}, 32'd0);
    endtask

    task automatic t_retrigger_ready;
        run_seq(0, "R8 rerun from ready");
    endtask

    task automatic t_drop_mid;
        repeat (3) @(negedge clk);
        run_seq(5, "R6 start dropped");
    endtask

    task automatic t_hold_after_done;
        repeat (3) @(negedge clk);
        @(negedge clk);
        seq_start = 1'b1;
        for (int k = 1; k <= 2*DK + 2; k++) begin
            @(negedge clk);
            if (k <= DK + 1) begin
                chk_cycle(k, "R7 first run");
            end else if (k == DK + 2) begin
                chk("R7 ready cleared", {31'd0, mem_ready}, 32'd0);
                chk("R7 cke low again", {31'd0, mem_cke}, 32'd0);
            end else begin
                chk("R7 second done", {31'd0, seq_done}, (k == 2*DK + 1) ? 32'd1 : 32'd0);
                if (k == 2*DK + 2)
                    chk("R7 second ready", {31'd0, mem_ready}, 32'd1);
            end
            if (k == DK + 5) seq_start = 1'b0;
        end
    endtask

    task automatic t_reset_mid;
        repeat (3) @(negedge clk);
        seq_start = 1'b1;
        repeat (TP + 4) @(negedge clk);
        rst = 1'b1;
        seq_start = 1'b0;
        @(negedge clk);
        chk_idle("R9 reset mid-sequence");
        rst = 1'b0;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            chk("R9 stays idle cmd", {29'd0, mem_cmd}, 32'd0);
            chk("R9 stays idle cke", {31'd0, mem_cke}, 32'd0);
        end
    endtask

    initial begin
        t_reset_state;
        t_basic;
        t_retrigger_ready;
        t_drop_mid;
        t_hold_after_done;
        t_reset_mid;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule